// File: doc/BRIEF.md
# Disable Tone Status Controller

This block sits beside one echo canceller channel. It takes the raw hits from two disable-tone detectors, one on the receive path and one on the send path, and turns them into a single sticky status bit. Once a hit sets the status, it stays high with no further tone. It drops only after every band-energy monitor on both paths has reported "below threshold" without a break for a programmable number of millisecond ticks. The default is 400 ticks.

Each rise and each fall of the status latches an active-low interrupt. The interrupt stays low until software writes a one-cycle clear. The block also holds the channel's adaptation/bypass state. In automatic mode the status drives that state. In manual mode the state follows a register-held command from the host. The tone-standard select bit is passed to each detector as its mode input.

There is no streaming data here. Every pin is a plain level or a single-cycle pulse sampled on the rising clock edge. None of them uses a handshake or back-pressure.

Top module: `tone_status_ctrl`

## Requirements
- R1: A synchronous reset leaves `td_status` at 0, `irq_n` at 1 and `bypass` at 0 (adaptation enabled), and zeroes the quiet timer.
- R2: When either bit of `tone_det` (bit 0 receive, bit 1 send) is 1 while `td_status` is 0, `td_status` is 1 and `irq_n` is 0 after the next rising edge.
- R3: While `td_status` is 1 it stays 1 with no tone present. A further tone hit while it is 1 raises no new interrupt.
- R4: `td_status` falls after the edge that samples the `QUIET_MS`-th consecutive `ms_tick` during which all bits of `quiet_flags` are 1 and no tone is present. After `QUIET_MS-1` such ticks it is still 1.
- R5: Any cycle in which a `quiet_flags` bit is 0 or a tone is present restarts the quiet count from zero.
- R6: The fall of `td_status` drives `irq_n` low in the same cycle.
- R7: `irq_n` stays low until a one-cycle `irq_clr` pulse arrives. It is then 1 after that edge.
- R8: When a set or release event and `irq_clr` fall in the same cycle, the event wins and `irq_n` stays 0.
- R9: Each bit of `det_mode_alt` equals `alt_std_sel` at all times. A 1 selects the tone standard that does not require phase reversal.
- R10: With `auto_mode` at 1, a set event makes `bypass` 1 in the same cycle that `td_status` rises. A release makes `bypass` 0 in the same cycle that `td_status` falls. `ext_bypass_cmd` is ignored.
- R11: With `auto_mode` at 0, `bypass` equals `ext_bypass_cmd` as sampled at the previous edge, whatever the tone activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tone_det | input | NUM_PATHS | Detector hit pulses, bit 0 receive, bit 1 send |
| quiet_flags | input | NUM_PATHS*NUM_BANDS | Below-threshold flags, bit p*NUM_BANDS+b for path p and band b |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| alt_std_sel | input | 1 | Tone standard select, 1 = no phase reversal needed |
| auto_mode | input | 1 | 1 = status drives bypass state |
| ext_bypass_cmd | input | 1 | Host bypass command used when auto_mode is 0 |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt |
| det_mode_alt | output | NUM_PATHS | Standard select delivered to each detector |
| td_status | output | 1 | Sticky tone-detect status |
| irq_n | output | 1 | Latched interrupt, active low |
| bypass | output | 1 | 1 = bypass, 0 = adaptation enabled |

## Verification
The interrupt latch can see a set or release event and a software clear in the same cycle. The bench holds `irq_clr` high in exactly the cycle that a tone hit reaches an idle channel, then checks that `irq_n` reads 0 and `td_status` reads 1 after that edge. The quiet timer can also see a tick and a broken quiet flag together. The bench drops one flag partway through a long quiet run and then shows that the status survives a further `QUIET_MS-1` ticks, which is only true if the count restarted.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic {
    ST_ADAPT  = 1'b0,
    ST_BYPASS = 1'b1
  } chan_state_e;
endpackage

// File: rtl/tsc_quiet_timer.sv
module tsc_quiet_timer #(
  parameter int unsigned QUIET_MS  = 400,
  parameter int unsigned NUM_FLAGS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 armed,
  input  logic                 tone_any,
  input  logic [NUM_FLAGS-1:0] quiet_flags,
  input  logic                 ms_tick,
  output logic                 release_pulse
);
  localparam int unsigned CW = $clog2(QUIET_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(QUIET_MS - 1);

  logic [CW-1:0] cnt_q;
  logic          all_quiet;
  logic          restart;

  assign all_quiet     = &quiet_flags;
  assign restart       = !armed || tone_any || !all_quiet;
  assign release_pulse = armed && !tone_any && all_quiet && ms_tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || release_pulse) begin
      cnt_q <= '0;
    end else if (ms_tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tsc_irq_latch.sv
module tsc_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic rel_evt,
  input  logic clr,
  output logic irq_n
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (set_evt || rel_evt) begin
      pend_q <= 1'b1;
    end else if (clr) begin
      pend_q <= 1'b0;
    end
  end

  assign irq_n = ~pend_q;
endmodule

// File: rtl/tsc_mode_fsm.sv
module tsc_mode_fsm
  import tsc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic auto_mode,
  input  logic ext_bypass_cmd,
  input  logic set_evt,
  input  logic rel_evt,
  output logic bypass
);
  chan_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (auto_mode) begin
      if (set_evt)      state_d = ST_BYPASS;
      else if (rel_evt) state_d = ST_ADAPT;
    end else begin
      state_d = ext_bypass_cmd ? ST_BYPASS : ST_ADAPT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_ADAPT;
    else     state_q <= state_d;
  end

  assign bypass = (state_q == ST_BYPASS);
endmodule

// File: rtl/tone_status_ctrl.sv
module tone_status_ctrl #(
  parameter int unsigned NUM_PATHS = 2,
  parameter int unsigned NUM_BANDS = 2,
  parameter int unsigned QUIET_MS  = 400
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PATHS-1:0]           tone_det,
  input  logic [NUM_PATHS*NUM_BANDS-1:0] quiet_flags,
  input  logic                           ms_tick,
  input  logic                           alt_std_sel,
  input  logic                           auto_mode,
  input  logic                           ext_bypass_cmd,
  input  logic                           irq_clr,
  output logic [NUM_PATHS-1:0]           det_mode_alt,
  output logic                           td_status,
  output logic                           irq_n,
  output logic                           bypass
);
  localparam int unsigned NUM_FLAGS = NUM_PATHS * NUM_BANDS;

  logic status_q;
  logic tone_any;
  logic set_evt;
  logic rel_evt;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_det_mode
    assign det_mode_alt[p] = alt_std_sel;
  end

  assign tone_any = |tone_det;
  assign set_evt  = tone_any && !status_q;

  tsc_quiet_timer #(
    .QUIET_MS (QUIET_MS),
    .NUM_FLAGS(NUM_FLAGS)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .armed        (status_q),
    .tone_any     (tone_any),
    .quiet_flags  (quiet_flags),
    .ms_tick      (ms_tick),
    .release_pulse(rel_evt)
  );

  always_ff @(posedge clk) begin
    if (rst)          status_q <= 1'b0;
    else if (set_evt) status_q <= 1'b1;
    else if (rel_evt) status_q <= 1'b0;
  end

  tsc_irq_latch u_irq (
    .clk    (clk),
    .rst    (rst),
    .set_evt(set_evt),
    .rel_evt(rel_evt),
    .clr    (irq_clr),
    .irq_n  (irq_n)
  );

  tsc_mode_fsm u_mode (
    .clk           (clk),
    .rst           (rst),
    .auto_mode     (auto_mode),
    .ext_bypass_cmd(ext_bypass_cmd),
    .set_evt       (set_evt),
    .rel_evt       (rel_evt),
    .bypass        (bypass)
  );

  assign td_status = status_q;
endmodule

// File: rtl/tone_status_ctrl_chk.sv
module tone_status_ctrl_chk #(
  parameter int unsigned NUM_PATHS = 2,
  parameter int unsigned NUM_BANDS = 2,
  parameter int unsigned QUIET_MS  = 400
) (
  input logic                           clk,
  input logic                           rst,
  input logic [NUM_PATHS-1:0]           tone_det,
  input logic [NUM_PATHS*NUM_BANDS-1:0] quiet_flags,
  input logic                           ms_tick,
  input logic                           auto_mode,
  input logic                           ext_bypass_cmd,
  input logic                           irq_clr,
  input logic                           td_status,
  input logic                           irq_n,
  input logic                           bypass
);
  localparam int unsigned CW = $clog2(QUIET_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(QUIET_MS - 1);

  logic          any_tone;
  logic          all_q;
  logic [CW-1:0] run_q;

  assign any_tone = |tone_det;
  assign all_q    = &quiet_flags;

  always_ff @(posedge clk) begin
    if (rst || !td_status || any_tone || !all_q) run_q <= '0;
    else if (ms_tick)                            run_q <= run_q + 1'b1;
  end

  assert_set_status_R2: assert property (@(posedge clk) disable iff (rst)
    (!td_status && any_tone) |=> (td_status && !irq_n));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (td_status && (any_tone || !all_q)) |=> td_status);

  assert_release_time_R4: assert property (@(posedge clk) disable iff (rst)
    (td_status && !any_tone && all_q && ms_tick && run_q == LAST) |=> !td_status);

  assert_no_early_release_R5: assert property (@(posedge clk) disable iff (rst)
    (td_status && run_q != LAST) |=> td_status);

  assert_release_irq_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(td_status) |-> !irq_n);

  assert_irq_clear_only_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(irq_n)) |-> $past(irq_clr));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !td_status && any_tone) |=> !irq_n);

  assert_auto_bypass_R10: assert property (@(posedge clk) disable iff (rst)
    (auto_mode && !td_status && any_tone) |=> bypass);

  assert_manual_follow_R11: assert property (@(posedge clk) disable iff (rst)
    !auto_mode |=> (bypass == $past(ext_bypass_cmd)));
endmodule

bind tone_status_ctrl tone_status_ctrl_chk #(
  .NUM_PATHS(NUM_PATHS),
  .NUM_BANDS(NUM_BANDS),
  .QUIET_MS (QUIET_MS)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tone_det      (tone_det),
  .quiet_flags   (quiet_flags),
  .ms_tick       (ms_tick),
  .auto_mode     (auto_mode),
  .ext_bypass_cmd(ext_bypass_cmd),
  .irq_clr       (irq_clr),
  .td_status     (td_status),
  .irq_n         (irq_n),
  .bypass        (bypass)
);

// File: tb/tone_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module tone_status_ctrl_tb_top;
  localparam int QMS = 400;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] tone_det;
  logic [3:0] quiet_flags;
  logic       ms_tick;
  logic       alt_std_sel;
  logic       auto_mode;
  logic       ext_bypass_cmd;
  logic       irq_clr;
  logic [1:0] det_mode_alt;
  logic       td_status;
  logic       irq_n;
  logic       bypass;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  tone_status_ctrl #(.NUM_PATHS(2), .NUM_BANDS(2), .QUIET_MS(QMS)) dut_i (
    .clk(clk), .rst(rst), .tone_det(tone_det), .quiet_flags(quiet_flags),
    .ms_tick(ms_tick), .alt_std_sel(alt_std_sel), .auto_mode(auto_mode),
    .ext_bypass_cmd(ext_bypass_cmd), .irq_clr(irq_clr),
    .det_mode_alt(det_mode_alt), .td_status(td_status), .irq_n(irq_n),
    .bypass(bypass)
  );

  // {tone[1:0], quiet[3:0], tick, clr, auto, ext, exp_status, exp_irq_n, exp_bypass}
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {2'b00, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b010},  // R1 idle
    {2'b01, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b101},  // R2 R10 rx hit
    {2'b00, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b101},  // R3 hold
    {2'b00, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b111},  // R7 clear
    {2'b10, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b111},  // R3 no re-irq
    {2'b00, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b110},  // R11 manual adapt
    {2'b00, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111},  // R11 manual bypass
    {2'b01, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b110}   // R11 tone ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    tone_det = 2'b00; ms_tick = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; idle_inputs();
    step(); step();
    rst = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      ms_tick = 1'b1; step();
      ms_tick = 1'b0; step(); step(); step();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tone_det = '0; quiet_flags = '0; ms_tick = 0; alt_std_sel = 0;
    auto_mode = 1; ext_bypass_cmd = 0; irq_clr = 0;
    #1;
    do_reset();
    check("R1 status", td_status, 0);
    check("R1 irq_n", irq_n, 1);
    check("R1 bypass", bypass, 0);

    for (int i = 0; i < NV; i++) begin
      tone_det       = VEC[i][12:11];
      quiet_flags    = VEC[i][10:7];
      ms_tick        = VEC[i][6];
      irq_clr        = VEC[i][5];
      auto_mode      = VEC[i][4];
      ext_bypass_cmd = VEC[i][3];
      step();
      check($sformatf("R2/R3/R7/R10/R11 vec%0d", i),
            {td_status, irq_n, bypass}, VEC[i][2:0]);
    end

    // R9 pass-through of the standard select
    alt_std_sel = 1'b1; #1;
    check("R9 alt=1", det_mode_alt, 2'b11);
    alt_std_sel = 1'b0; #1;
    check("R9 alt=0", det_mode_alt, 2'b00);

    // Quiet timer: R4 R5 R6 R10
    do_reset();
    auto_mode = 1; ext_bypass_cmd = 0; quiet_flags = 4'h0;
    tone_det = 2'b10; step(); tone_det = 2'b00;
    check("R10 auto bypass", bypass, 1);
    irq_clr = 1; step(); irq_clr = 0;
    check("R7 cleared", irq_n, 1);
    quiet_flags = 4'hF;
    run_ticks(200);
    quiet_flags = 4'hB; step(); quiet_flags = 4'hF;
    run_ticks(QMS - 1);
    check("R5 restart keeps status", td_status, 1);
    check("R5 no irq yet", irq_n, 1);
    ms_tick = 1'b1; step(); ms_tick = 1'b0;
    check("R4 release", td_status, 0);
    check("R6 release irq", irq_n, 0);
    check("R10 back to adapt", bypass, 0);
    step();
    check("R7 irq held", irq_n, 0);

    // R8 set beats clear
    irq_clr = 1; step(); irq_clr = 0;
    check("R7 clear after release", irq_n, 1);
    quiet_flags = 4'h0;
    tone_det = 2'b01; irq_clr = 1; step();
    tone_det = 2'b00; irq_clr = 0;
    check("R8 irq stays low", irq_n, 0);
    check("R8 status set", td_status, 1);

    // R11 manual mode set leaves state untouched
    do_reset();
    auto_mode = 0; ext_bypass_cmd = 0;
    tone_det = 2'b01; step(); tone_det = 2'b00;
    check("R11 status set", td_status, 1);
    check("R11 no auto bypass", bypass, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule